// File: doc/BRIEF.md
# First-Edge Wakeup Stretch Sequencer

This block runs a one-time wakeup handshake for a slave on a three-wire synchronous link with a shared, open-drain clock. The shift engine reports a synchronized pulse each time it sees an edge on the shared clock. After enable, the first such pulse that is not caused by the slave's own acknowledge pulse starts a timed sequence. The sequence waits a configurable delay. It then releases the outbound data line and pauses for a short gap. Next it pulls the shared clock low for a long stretch and releases it. Finally it posts a forced reply byte to the reply source.

During the gap and the stretch, the block raises a busy flag. The shift engine uses this flag to freeze its falling-edge transmit updates, so the data line stays released. The forced byte goes into its own pending slot and stays there until the reply source takes it, so any reply already staged elsewhere is left alone.

The sequence runs once per enable. Dropping enable aborts a run in progress, releases both lines, clears the pending byte and re-arms the trigger. All durations are given in microseconds and are counted with a tick derived from the system clock.

Top module: `wake_stretch_seq`

## Requirements
- R1: After reset, data_release, clk_pull_low, hold_busy and force_valid are all low, and force_byte always equals the FORCE_BYTE parameter (default 8'hAA).
- R2: A sequence starts only on a clock edge where en=1, first_edge=1 and ack_active=0, and the block is armed. A first_edge pulse with ack_active=1 starts nothing.
- R3: If the trigger is sampled at edge k, data_release rises after edge k+D, where D = WAIT_US*CLK_PER_US. Before that, all outputs stay low.
- R4: data_release stays high for G+H cycles, where G = GAP_US*CLK_PER_US and H = HOLD_US*CLK_PER_US. clk_pull_low is high only during the last H of those cycles. hold_busy is high exactly while data_release is high.
- R5: Further first_edge pulses during a running sequence do not change its timing.
- R6: force_valid rises on the same edge on which clk_pull_low falls at the end of a full hold. It stays high until force_taken is sampled high, and clears on the next edge after that.
- R7: Once the sequence has completed, further first_edge pulses start nothing until enable is dropped.
- R8: When en is sampled low, the next edge forces all four outputs low and re-arms the trigger. A later trigger then runs the full sequence again.
- R9: force_taken has no effect while force_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low aborts and re-arms |
| first_edge | input | 1 | Synchronized shared-clock edge pulse from the shift engine |
| ack_active | input | 1 | High while the slave's own acknowledge pulse drives the clock |
| force_taken | input | 1 | Reply source consumes the forced byte |
| data_release | output | 1 | Hold the outbound data line released |
| clk_pull_low | output | 1 | Drive the shared clock low |
| hold_busy | output | 1 | Freeze transmit updates in the shift engine |
| force_valid | output | 1 | Forced reply byte is pending |
| force_byte | output | 8 | Forced reply byte value |

## Verification
The bench sweeps an abort through every cycle offset of the sequence, from the trigger edge to past completion. A design that failed to clear the pending byte, or left a line driven on abort, would show a stale output the cycle after enable falls. After each abort it runs a full sequence again, which exposes a trigger that never re-arms. Timing is compared cycle by cycle against the computed delay, gap and hold bounds. An off-by-one tick counter would move an edge by a cycle. Other cases covered are:
- trigger pulses that overlap an acknowledge, which a wrong design would treat as a start;
- repeated pulses during and after the run, which would restart or lengthen the stretch;
- a take strobe with nothing pending.

// File: rtl/wss_pkg.sv
package wss_pkg;
  typedef enum logic [2:0] {
    WS_ARMED = 3'd0,
    WS_DELAY = 3'd1,
    WS_GAP   = 3'd2,
    WS_HOLD  = 3'd3,
    WS_SPENT = 3'd4
  } wss_state_e;
endpackage

// File: rtl/wss_us_tick.sv
module wss_us_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wss_span_timer.sv
module wss_span_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign expire = run && tick && (cnt_q == limit - W'(1));
  assign cnt_en = !run || tick;

  always_comb begin
    if (!run || expire) cnt_d = '0;
    else                cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wss_force_slot.sv
module wss_force_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic post,
  input  logic take,
  output logic valid
);
  logic valid_q, valid_d;

  always_comb begin
    valid_d = valid_q;
    if (!en)            valid_d = 1'b0;
    else if (post)      valid_d = 1'b1;
    else if (take)      valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign valid = valid_q;
endmodule

// File: rtl/wake_stretch_seq.sv
module wake_stretch_seq
  import wss_pkg::*;
#(
  parameter int          CLK_PER_US = 200,
  parameter int          WAIT_US    = 250,
  parameter int          GAP_US     = 10,
  parameter int          HOLD_US    = 3000,
  parameter logic [7:0]  FORCE_BYTE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       first_edge,
  input  logic       ack_active,
  input  logic       force_taken,
  output logic       data_release,
  output logic       clk_pull_low,
  output logic       hold_busy,
  output logic       force_valid,
  output logic [7:0] force_byte
);
  localparam int SPAN_MAX_A = (WAIT_US > GAP_US) ? WAIT_US : GAP_US;
  localparam int SPAN_MAX   = (SPAN_MAX_A > HOLD_US) ? SPAN_MAX_A : HOLD_US;
  localparam int SPAN_W     = $clog2(SPAN_MAX + 1);

  wss_state_e        state_q, state_d;
  logic              run, tick, expire, post;
  logic [SPAN_W-1:0] limit;

  assign run = (state_q == WS_DELAY) || (state_q == WS_GAP) || (state_q == WS_HOLD);

  always_comb begin
    case (state_q)
      WS_GAP:  limit = SPAN_W'(GAP_US);
      WS_HOLD: limit = SPAN_W'(HOLD_US);
      default: limit = SPAN_W'(WAIT_US);
    endcase
  end

  wss_us_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  wss_span_timer #(.W(SPAN_W)) u_span (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .limit (limit),
    .expire(expire)
  );

  // next state
  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = WS_ARMED;
    end else begin
      case (state_q)
        WS_ARMED: if (first_edge && !ack_active) state_d = WS_DELAY;
        WS_DELAY: if (expire) state_d = WS_GAP;
        WS_GAP:   if (expire) state_d = WS_HOLD;
        WS_HOLD:  if (expire) state_d = WS_SPENT;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_ARMED;
    else        state_q <= state_d;
  end

  assign post = en && (state_q == WS_HOLD) && expire;

  wss_force_slot u_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .post (post),
    .take (force_taken),
    .valid(force_valid)
  );

  assign data_release = (state_q == WS_GAP) || (state_q == WS_HOLD);
  assign clk_pull_low = (state_q == WS_HOLD);
  assign hold_busy    = data_release;
  assign force_byte   = FORCE_BYTE;
endmodule

// File: rtl/wss_checker.sv
module wss_checker #(
  parameter int HOLD_CYC = 600000
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic force_taken,
  input logic data_release,
  input logic clk_pull_low,
  input logic hold_busy,
  input logic force_valid
);
  int unsigned hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hold_cnt <= 0;
    else if (clk_pull_low) hold_cnt <= hold_cnt + 1;
    else                   hold_cnt <= 0;
  end

  assert_pull_inside_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_pull_low |-> data_release);

  assert_busy_covers_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_pull_low |-> hold_busy);

  assert_release_before_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_pull_low) |-> $past(data_release));

  assert_full_hold_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_pull_low) && $past(en)) |-> (hold_cnt == HOLD_CYC));

  assert_post_at_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_valid) |-> ($past(clk_pull_low) && !clk_pull_low));

  assert_pending_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_valid && !force_taken && en) |=> force_valid);

  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!data_release && !clk_pull_low && !force_valid));
endmodule

bind wake_stretch_seq wss_checker #(.HOLD_CYC(HOLD_US * CLK_PER_US)) u_wss_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .force_taken (force_taken),
  .data_release(data_release),
  .clk_pull_low(clk_pull_low),
  .hold_busy   (hold_busy),
  .force_valid (force_valid)
);

// File: tb/sim_wake_stretch_seq.sv
`timescale 1ns/1ps
module sim_wake_stretch_seq;
  localparam int P   = 2;
  localparam int WU  = 5;
  localparam int GU  = 2;
  localparam int HU  = 12;
  localparam int D   = WU * P;
  localparam int G   = GU * P;
  localparam int H   = HU * P;
  localparam int TOT = D + G + H;

  logic clk = 1'b0;
  logic rst_n, en, first_edge, ack_active, force_taken;
  logic data_release, clk_pull_low, hold_busy, force_valid;
  logic [7:0] force_byte;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wake_stretch_seq #(
    .CLK_PER_US(P), .WAIT_US(WU), .GAP_US(GU), .HOLD_US(HU), .FORCE_BYTE(8'hAA)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .first_edge(first_edge),
    .ack_active(ack_active), .force_taken(force_taken),
    .data_release(data_release), .clk_pull_low(clk_pull_low),
    .hold_busy(hold_busy), .force_valid(force_valid), .force_byte(force_byte)
  );

  function automatic logic [3:0] expect_at(int n);
    logic rel, pull, fv;
    rel  = (n >= D) && (n < TOT);
    pull = (n >= D + G) && (n < TOT);
    fv   = (n >= TOT);
    return {rel, rel, pull, fv};
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {hold_busy, data_release, clk_pull_low, force_valid};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s busy/rel/pull/fv actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // trigger, then compare every cycle; abort_at<0 runs to completion
  task automatic run_seq(int abort_at, bit spam);
    @(negedge clk);
    first_edge = 1'b1;
    @(negedge clk);
    first_edge = spam;
    for (int n = 0; n <= TOT + 2; n++) begin
      if (n > 0) @(negedge clk);
      check(spam ? "R5" : "R3/R4/R6", expect_at(n));
      if (n == abort_at) begin
        en = 1'b0;
        @(negedge clk);
        check("R8", 4'b0000);
        en = 1'b1;
        first_edge = 1'b0;
        return;
      end
    end
    first_edge = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; first_edge = 1'b0; ack_active = 1'b0; force_taken = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 4'b0000);
    checks++;
    if (force_byte !== 8'hAA) begin
      failures++;
      $display("FAIL R1 force_byte actual=%h expected=aa", force_byte);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 4'b0000);

    // R2: edge while disabled, then edge overlapping own acknowledge
    first_edge = 1'b1;
    @(negedge clk);
    first_edge = 1'b0;
    en = 1'b1;
    @(negedge clk);
    first_edge = 1'b1; ack_active = 1'b1;
    @(negedge clk);
    first_edge = 1'b0; ack_active = 1'b0;
    for (int n = 0; n < D + 3; n++) begin
      @(negedge clk);
      check("R2", 4'b0000);
    end

    // full run with stray pulses throughout
    run_seq(-1, 1'b1);
    // R7: completed, new pulse does nothing
    first_edge = 1'b1;
    for (int n = 0; n < TOT + 2; n++) begin
      @(negedge clk);
      check("R7", 4'b0001);
    end
    first_edge = 1'b0;
    // R6: take clears pending
    force_taken = 1'b1;
    @(negedge clk);
    force_taken = 1'b0;
    check("R6", 4'b0000);
    // R9: take with nothing pending
    force_taken = 1'b1;
    @(negedge clk);
    force_taken = 1'b0;
    check("R9", 4'b0000);
    @(negedge clk);
    check("R9", 4'b0000);

    // R8: abort sweep over every offset, each followed by a full run
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    for (int a = 0; a <= TOT + 1; a++) begin
      run_seq(a, 1'b0);
      run_seq(-1, 1'b0);
      en = 1'b0;
      @(negedge clk);
      check("R8", 4'b0000);
      en = 1'b1;
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule